// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block receives asynchronous serial characters on a single line and checks each one for line noise and framing errors. It takes an oversampling clock enable that pulses sixteen times per bit period. Each pulse is one RT cycle, and a bit period spans RT1 through RT16. The receiver takes three samples of every bit at RT8, RT9 and RT10 and keeps the majority value. It reports any disagreement among the three samples as noise. A stop bit that reads mostly low raises a framing error.

A falling edge on the line starts a character, but only when the line was high before the edge. The receiver shifts in data bits least significant bit first. A mode input selects 8 or 9 data bits per character. Falling edges between data bits re-time the RT counter, so the receiver tolerates transmitters that run somewhat slow or fast. After the stop bit is judged, the receiver presents the data word and both error flags, with a one-clock valid pulse.

Top module: `uart_os_rx`

## Requirements
- R1: While reset is active and after it is released, `rx_valid`, `rx_noise`, `rx_frame_err` and `rx_data` read zero until the first character completes.
- R2: A bit lasts 16 RT cycles. Its value is the majority of the line samples at RT8, RT9 and RT10, counting the first RT cycle in which the start edge is seen as RT1. Data bits arrive least significant first, and bit 0 appears at `rx_data[0]`.
- R3: A character starts only on a high-to-low change of the line after it was sampled high. If the majority of the start bit's three samples is high, the event is a false start: no character is delivered and the receiver waits for a new edge.
- R4: If the three samples of the start bit, any data bit or the stop bit are not all equal, `rx_noise` is set for that character and the majority value is used.
- R5: If two or three stop-bit samples are low, `rx_frame_err` is set and the character is still delivered.
- R6: With `len9_mode`=1 a character has 9 data bits, delivered in `rx_data[8:0]`. With `len9_mode`=0 it has 8, in `rx_data[7:0]`, and `rx_data[8]` reads 0.
- R7: `len9_mode` is captured in the RT cycle that detects the start edge. Changing it while a character is in progress does not affect that character.
- R8: `rx_valid` is high for exactly one clock, in the clock after the RT10 stop sample. `rx_data` and both flags change together with it and hold until the next character.
- R9: After the start bit, a falling edge seen at RT2–RT7 makes that RT cycle RT1 of the current bit. A falling edge seen at RT11–RT16 makes it RT1 of the next bit.
- R10: A stop bit that begins at RT8 of its expected period is received with no error. If it begins at RT9 only noise is flagged. If it begins at RT10, both noise and framing error are flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rt_tick | input | 1 | Oversampling enable, one pulse per RT cycle (16 per bit) |
| rxd_in | input | 1 | Asynchronous serial line, idle high |
| len9_mode | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| rx_data | output | 9 | Received data word, least significant bit first on the line |
| rx_valid | output | 1 | One-clock pulse when a character completes |
| rx_noise | output | 1 | Sample disagreement seen in the character |
| rx_frame_err | output | 1 | Stop bit judged low |

## Verification
On every cycle the assertions check the following invariants. The valid strobe lasts one clock. The RT counter stays in the range 1 to 16 while a character is in progress. A start bit voted high returns the receiver to idle with no output. A low stop-bit vote or a stop-bit disagreement always shows up in the flags delivered with that character. The ninth data bit reads zero in 8-bit mode.

Only the bench scenarios can show the rest. They show that majority voting recovers the data, that a single glitch in a start, data or stop bit is flagged as noise, and that re-timing on falling edges keeps transmitters at 14 and 18 RT cycles per bit correctly aligned. They also probe the exact stop-bit lateness boundary at RT8, RT9 and RT10, where the outcome moves from clean to noise to framing error.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/uart_os_rx_rstsync.sv
module uart_os_rx_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/uart_os_rx_linesync.sv
module uart_os_rx_linesync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rt_tick,
  input  logic rxd_in,
  output logic line_smp,
  output logic line_fall
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   prev_d;

  // metastability chain, idle level is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd_in};
  end

  assign line_smp = sync_q[SYNC_STAGES-1];

  always_comb begin
    prev_d = prev_q;
    if (rt_tick) prev_d = line_smp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= prev_d;
  end

  assign line_fall = rt_tick & prev_q & ~line_smp;
endmodule

// File: rtl/uart_os_rx_vote.sv
module uart_os_rx_vote #(
  parameter int OSR = 16,
  localparam int CW = $clog2(OSR + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rt_tick,
  input  logic [CW-1:0] rt_cur,
  input  logic          line_smp,
  output logic          vote_maj,
  output logic          vote_noise
);
  localparam int MID = OSR / 2 + 1;
  localparam logic [CW-1:0] RT_S0 = CW'(MID - 1);
  localparam logic [CW-1:0] RT_S1 = CW'(MID);

  logic s0_q, s1_q, s0_d, s1_d;

  always_comb begin
    s0_d = s0_q;
    s1_d = s1_q;
    if (rt_tick && rt_cur == RT_S0) s0_d = line_smp;
    if (rt_tick && rt_cur == RT_S1) s1_d = line_smp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q <= 1'b1;
      s1_q <= 1'b1;
    end else begin
      s0_q <= s0_d;
      s1_q <= s1_d;
    end
  end

  // third sample is the live one, taken in the evaluating RT cycle
  assign vote_maj   = (s0_q & s1_q) | (s0_q & line_smp) | (s1_q & line_smp);
  assign vote_noise = ~((s0_q == s1_q) && (s1_q == line_smp));
endmodule

// File: rtl/uart_os_rx_ctrl.sv
module uart_os_rx_ctrl
  import uart_os_rx_pkg::*;
#(
  parameter int OSR      = 16,
  parameter int DATA_MAX = 9,
  localparam int CW = $clog2(OSR + 1),
  localparam int IW = $clog2(DATA_MAX)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rt_tick,
  input  logic                line_fall,
  input  logic                len9_mode,
  input  logic                vote_maj,
  input  logic                vote_noise,
  output logic [CW-1:0]       rt_cur,
  output logic [DATA_MAX-1:0] rx_data,
  output logic                rx_valid,
  output logic                rx_noise,
  output logic                rx_frame_err
);
  localparam int MID = OSR / 2 + 1;
  localparam logic [CW-1:0] RT_ONE    = CW'(1);
  localparam logic [CW-1:0] RT_TWO    = CW'(2);
  localparam logic [CW-1:0] RT_EVAL   = CW'(MID + 1);
  localparam logic [CW-1:0] RT_LAST   = CW'(OSR);
  localparam logic [CW-1:0] EARLY_MAX = CW'(MID - 2);
  localparam logic [CW-1:0] LATE_MIN  = CW'(MID + 2);
  localparam logic [IW-1:0] IDX_LONG  = IW'(DATA_MAX - 1);
  localparam logic [IW-1:0] IDX_SHORT = IW'(DATA_MAX - 2);

  rx_state_e           st_q, st_d;
  logic [CW-1:0]       rt_q, rt_d;
  logic [IW-1:0]       idx_q, idx_d;
  logic                m9_q, m9_d;
  logic [DATA_MAX-1:0] sh_q, sh_d;
  logic                nacc_q, nacc_d;
  logic [DATA_MAX-1:0] dat_q, dat_d;
  logic                vld_q, vld_d;
  logic                nf_q, nf_d;
  logic                fe_q, fe_d;
  logic                bit_end;
  logic [IW-1:0]       idx_last;

  assign idx_last = m9_q ? IDX_LONG : IDX_SHORT;
  assign bit_end  = (rt_q == RT_LAST) || (line_fall && rt_q >= LATE_MIN);

  always_comb begin
    st_d   = st_q;
    rt_d   = rt_q;
    idx_d  = idx_q;
    m9_d   = m9_q;
    sh_d   = sh_q;
    nacc_d = nacc_q;
    dat_d  = dat_q;
    vld_d  = 1'b0;
    nf_d   = nf_q;
    fe_d   = fe_q;
    if (rt_tick) begin
      if (st_q == RX_IDLE) begin
        if (line_fall) begin
          st_d   = RX_START;
          rt_d   = RT_TWO;
          idx_d  = '0;
          m9_d   = len9_mode;
          nacc_d = 1'b0;
        end
      end else begin
        rt_d = rt_q + 1'b1;
        // slow sender: edge before the sample window re-times this bit
        if (line_fall && rt_q >= RT_TWO && rt_q <= EARLY_MAX) rt_d = RT_TWO;
        if (rt_q == RT_EVAL) begin
          case (st_q)
            RX_START: begin
              if (vote_maj) st_d = RX_IDLE;
              else          nacc_d = nacc_q | vote_noise;
            end
            RX_DATA: begin
              sh_d   = {vote_maj, sh_q[DATA_MAX-1:1]};
              nacc_d = nacc_q | vote_noise;
            end
            RX_STOP: begin
              vld_d = 1'b1;
              dat_d = m9_q ? sh_q : {1'b0, sh_q[DATA_MAX-1:1]};
              nf_d  = nacc_q | vote_noise;
              fe_d  = ~vote_maj;
              st_d  = RX_IDLE;
            end
            default: ;
          endcase
        end
        // end of bit, or fast sender whose next bit has already begun
        if (bit_end && st_q != RX_STOP && st_d != RX_IDLE) begin
          rt_d = line_fall ? RT_TWO : RT_ONE;
          if (st_q == RX_START) begin
            st_d  = RX_DATA;
            idx_d = '0;
          end else if (idx_q == idx_last) begin
            st_d = RX_STOP;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      rt_q   <= RT_ONE;
      idx_q  <= '0;
      m9_q   <= 1'b0;
      sh_q   <= '0;
      nacc_q <= 1'b0;
      dat_q  <= '0;
      vld_q  <= 1'b0;
      nf_q   <= 1'b0;
      fe_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      rt_q   <= rt_d;
      idx_q  <= idx_d;
      m9_q   <= m9_d;
      sh_q   <= sh_d;
      nacc_q <= nacc_d;
      dat_q  <= dat_d;
      vld_q  <= vld_d;
      nf_q   <= nf_d;
      fe_q   <= fe_d;
    end
  end

  assign rt_cur       = rt_q;
  assign rx_data      = dat_q;
  assign rx_valid     = vld_q;
  assign rx_noise     = nf_q;
  assign rx_frame_err = fe_q;

  p_valid_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);

  p_rt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != RX_IDLE) |-> (rt_q >= RT_ONE && rt_q <= RT_LAST));

  p_false_start_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_tick && st_q == RX_START && rt_q == RT_EVAL && vote_maj)
      |=> (st_q == RX_IDLE && !vld_q));

  p_fe_on_low_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_tick && st_q == RX_STOP && rt_q == RT_EVAL && !vote_maj)
      |=> (vld_q && fe_q));

  p_noise_on_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_tick && st_q == RX_STOP && rt_q == RT_EVAL && vote_noise)
      |=> (vld_q && nf_q));

  p_msb_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !m9_q) |-> (dat_q[DATA_MAX-1] == 1'b0));
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx #(
  parameter int OSR         = 16,
  parameter int DATA_MAX    = 9,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rt_tick,
  input  logic                rxd_in,
  input  logic                len9_mode,
  output logic [DATA_MAX-1:0] rx_data,
  output logic                rx_valid,
  output logic                rx_noise,
  output logic                rx_frame_err
);
  localparam int CW = $clog2(OSR + 1);

  logic          rst_n_s;
  logic          line_smp;
  logic          line_fall;
  logic          vote_maj;
  logic          vote_noise;
  logic [CW-1:0] rt_cur;

  uart_os_rx_rstsync #(.STAGES(RST_STAGES)) i_rstsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  uart_os_rx_linesync #(.SYNC_STAGES(SYNC_STAGES)) i_linesync (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .rt_tick   (rt_tick),
    .rxd_in    (rxd_in),
    .line_smp  (line_smp),
    .line_fall (line_fall)
  );

  uart_os_rx_vote #(.OSR(OSR)) i_vote (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .rt_tick    (rt_tick),
    .rt_cur     (rt_cur),
    .line_smp   (line_smp),
    .vote_maj   (vote_maj),
    .vote_noise (vote_noise)
  );

  uart_os_rx_ctrl #(.OSR(OSR), .DATA_MAX(DATA_MAX)) i_ctrl (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .rt_tick      (rt_tick),
    .line_fall    (line_fall),
    .len9_mode    (len9_mode),
    .vote_maj     (vote_maj),
    .vote_noise   (vote_noise),
    .rt_cur       (rt_cur),
    .rx_data      (rx_data),
    .rx_valid     (rx_valid),
    .rx_noise     (rx_noise),
    .rx_frame_err (rx_frame_err)
  );
endmodule

// File: tb/test_uart_os_rx.sv
module test_uart_os_rx;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_RT     = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rt_tick;
  logic       rxd_in;
  logic       len9_mode;
  logic [8:0] rx_data;
  logic       rx_valid;
  logic       rx_noise;
  logic       rx_frame_err;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 1'b0;

  logic [10:0] exp_q[$];
  string       tag_q[$];

  uart_os_rx i_uart_os_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .rt_tick      (rt_tick),
    .rxd_in       (rxd_in),
    .len9_mode    (len9_mode),
    .rx_data      (rx_data),
    .rx_valid     (rx_valid),
    .rx_noise     (rx_noise),
    .rx_frame_err (rx_frame_err)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // one RT cycle every two clocks
  initial begin
    rt_tick = 1'b0;
    forever begin
      @(negedge clk);
      rt_tick = ~rt_tick;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int rts);
    rxd_in = v;
    repeat (2 * rts) @(negedge clk);
  endtask

  task automatic drive_bit(input logic v, input int len, input bit glitch);
    if (glitch) begin
      hold(v, 8);
      hold(~v, 1);
      hold(v, len - 9);
    end else begin
      hold(v, len);
    end
  endtask

  // glitch_at: -1 none, 0 start, 1..nb data bit, nb+1 stop
  task automatic tx(input logic [8:0] d, input bit nine, input int blen,
                    input int ext_last, input int glitch_at, input bit stop_low,
                    input bit flip, input logic [8:0] ed, input bit enf,
                    input bit efe, input string tag);
    int nb;
    nb = nine ? 9 : 8;
    exp_q.push_back({ed, enf, efe});
    tag_q.push_back(tag);
    len9_mode = nine;
    drive_bit(1'b0, blen, glitch_at == 0);
    if (flip) len9_mode = ~nine;
    for (int i = 0; i < nb; i++) begin
      drive_bit(d[i], blen + ((i == nb - 1) ? ext_last : 0), glitch_at == i + 1);
    end
    if (stop_low) hold(1'b0, blen);
    else          drive_bit(1'b1, blen, glitch_at == nb + 1);
    hold(1'b1, 20);
    len9_mode = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1 && rx_valid === 1'b1) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3", "unexpected character", {20'd0, rx_data, rx_noise, rx_frame_err}, 0);
      end else begin
        logic [10:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rx_data === e[10:2], t, "data", rx_data, e[10:2]);
        chk(rx_noise === e[1], t, "noise flag (R4)", rx_noise, e[1]);
        chk(rx_frame_err === e[0], t, "framing flag (R5)", rx_frame_err, e[0]);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    rxd_in    = 1'b1;
    len9_mode = 1'b0;
    repeat (5) @(negedge clk);
    chk(rx_valid === 1'b0, "R1", "valid in reset", rx_valid, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(rx_valid === 1'b0, "R1", "valid after reset", rx_valid, 0);
    chk(rx_noise === 1'b0 && rx_frame_err === 1'b0, "R1", "flags after reset",
        {rx_noise, rx_frame_err}, 0);
    chk(rx_data === 9'd0, "R1", "data after reset", rx_data, 0);
    hold(1'b1, 10);

    // R2: plain 8-bit characters, LSB first
    tx(9'h0A5, 0, BIT_RT, 0, -1, 0, 0, 9'h0A5, 0, 0, "R2");
    tx(9'h000, 0, BIT_RT, 0, -1, 0, 0, 9'h000, 0, 0, "R2");
    tx(9'h0FF, 0, BIT_RT, 0, -1, 0, 0, 9'h0FF, 0, 0, "R2");
    tx(9'h03C, 0, BIT_RT, 0, -1, 0, 0, 9'h03C, 0, 0, "R2");
    // R6: ninth bit not taken in 8-bit mode; 9-bit characters
    tx(9'h1C3, 0, BIT_RT, 0, -1, 0, 0, 9'h0C3, 0, 0, "R6");
    tx(9'h1A5, 1, BIT_RT, 0, -1, 0, 0, 9'h1A5, 0, 0, "R6");
    tx(9'h100, 1, BIT_RT, 0, -1, 0, 0, 9'h100, 0, 0, "R6");
    tx(9'h0FF, 1, BIT_RT, 0, -1, 0, 0, 9'h0FF, 0, 0, "R6");
    // R4: single-sample glitch in start, data and stop bits
    tx(9'h05A, 0, BIT_RT, 0, 4, 0, 0, 9'h05A, 1, 0, "R4");
    tx(9'h081, 0, BIT_RT, 0, 9, 0, 0, 9'h081, 1, 0, "R4");
    tx(9'h033, 0, BIT_RT, 0, 0, 0, 0, 9'h033, 1, 0, "R4");
    // R5: stop bit held low
    tx(9'h07E, 0, BIT_RT, 0, -1, 1, 0, 9'h07E, 0, 1, "R5");
    // R3: false start, then a good character
    hold(1'b0, 3);
    hold(1'b1, 30);
    chk(exp_q.size() == 0, "R3", "queue empty after false start", exp_q.size(), 0);
    tx(9'h042, 0, BIT_RT, 0, -1, 0, 0, 9'h042, 0, 0, "R3");
    // R10: late stop bit at RT8 / RT9 / RT10
    tx(9'h000, 0, BIT_RT, 7, -1, 0, 0, 9'h000, 0, 0, "R10");
    tx(9'h000, 0, BIT_RT, 8, -1, 0, 0, 9'h000, 1, 0, "R10");
    tx(9'h000, 0, BIT_RT, 9, -1, 0, 0, 9'h000, 1, 1, "R10");
    tx(9'h000, 1, BIT_RT, 7, -1, 0, 0, 9'h000, 0, 0, "R10");
    // R9: re-timing on falling edges, fast and slow senders
    tx(9'h055, 0, 14, 0, -1, 0, 0, 9'h055, 0, 0, "R9");
    tx(9'h055, 0, 18, 0, -1, 0, 0, 9'h055, 0, 0, "R9");
    tx(9'h155, 1, 14, 0, -1, 0, 0, 9'h155, 0, 0, "R9");
    // R7: mode change after start has no effect
    tx(9'h196, 0, BIT_RT, 0, -1, 0, 1, 9'h096, 0, 0, "R7");
    // R8: valid is a single-clock pulse with held outputs
    tx(9'h0C9, 0, BIT_RT, 0, -1, 0, 0, 9'h0C9, 0, 0, "R8");
    chk(rx_valid === 1'b0, "R8", "valid low after pulse", rx_valid, 0);
    chk(rx_data === 9'h0C9, "R8", "data held after pulse", rx_data, 9'h0C9);

    chk(exp_q.size() == 0, "R8", "all expected characters delivered", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule